// File: doc/BRIEF.md
# Shift, Rotate and Logic Unit

This block is a combinational execution unit for the register-to-register bitwise and shift operations of a three-operand integer datapath. A group select picks one of two families. The logic family computes bitwise functions of operands b and c. The shift family moves the bits of b by the amount held in c, or rotates them. A 4-bit function code selects the operation within the family. The result is available in the same cycle.

Codes that neither family defines raise an illegal flag and force the result to zero, so the issue stage can trap them. Immediate-operand forms can use the same unit by driving c from a zero-extended 16-bit immediate. The datapath width is a parameter and defaults to 32 bits.

Top module: `slu_top`

## Requirements
- R1: With group select 0 (logic), codes 0, 1 and 2 give b AND c, b OR c and b XOR c.
- R2: Logic codes 3, 4 and 5 give the bitwise complements of codes 0, 1 and 2 (NAND, NOR and XNOR).
- R3: Logic code 6 gives (~b & c), and logic code 7 gives (b & ~c).
- R4: Logic code 8 gives (~b | c), and logic code 9 gives (b | ~c).
- R5: Logic codes 10 to 15 set illegal to 1 and give a result of 0.
- R6: With group select 1 (shift), code 0 shifts b left and fills the vacated bits with zeros. Code 1 shifts b right and copies the sign bit (bit WIDTH-1) into the vacated bits.
- R7: Shift codes 2 and 3 shift b left and right and fill the vacated bits with zeros.
- R8: Shift codes 4 and 5 shift b left and right and fill the vacated bits with ones.
- R9: For shift codes 0 to 5, a shift amount c of WIDTH or more gives the full fill pattern. This is all zeros for codes 0, 2 and 3, all copies of the sign bit for code 1, and all ones for codes 4 and 5.
- R10: Shift codes 6 and 7 rotate b left and right by (c modulo WIDTH) positions.
- R11: Shift codes 8 to 15 set illegal to 1 and give a result of 0.
- R12: Every defined code drives illegal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grp_sel | input | 1 | Family select: 0 selects logic, 1 selects shift/rotate |
| func | input | 4 | Function code within the selected family |
| opb | input | WIDTH | Operand b: logic input, or the value that is shifted |
| opc | input | WIDTH | Operand c: logic input, or the shift/rotate amount |
| res | output | WIDTH | Result a |
| illegal | output | 1 | Set for reserved codes |

## Verification
The bench targets shift amounts at and just beyond the boundaries: 0, WIDTH-1, exactly WIDTH, and large values whose low bits alias a small amount. A unit that truncates the amount to its low bits would return a partly shifted value where the full fill pattern is expected. Rotates run with amounts of WIDTH and WIDTH+3, so a unit that fails to reduce c modulo WIDTH would zero the result instead of wrapping it. The bench checks arithmetic right shifts on both negative and positive values, because a unit that swaps the zero fill and sign fill only shows the error on negative values. The bench also checks the swapped operand order of the two implication pairs and every reserved code in both families, which must all give zero with illegal set.

// File: rtl/slu_pkg.sv
package slu_pkg;
  typedef enum logic [3:0] {
    LG_AND = 4'd0, LG_OR = 4'd1, LG_XOR = 4'd2,
    LG_NAND = 4'd3, LG_NOR = 4'd4, LG_XNOR = 4'd5,
    LG_CNIMP = 4'd6, LG_MNIMP = 4'd7, LG_MIMP = 4'd8, LG_CIMP = 4'd9
  } logic_fn_e;

  typedef enum logic [3:0] {
    SH_ALEFT = 4'd0, SH_ARIGHT = 4'd1, SH_ZLEFT = 4'd2, SH_ZRIGHT = 4'd3,
    SH_OLEFT = 4'd4, SH_ORIGHT = 4'd5, SH_ROTL = 4'd6, SH_ROTR = 4'd7
  } shift_fn_e;

  localparam logic GRP_LOGIC = 1'b0;
  localparam logic GRP_SHIFT = 1'b1;
endpackage

// File: rtl/slu_logic.sv
module slu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       func,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] opc,
  output logic [WIDTH-1:0] res,
  output logic             bad
);
  import slu_pkg::*;

  logic [WIDTH-1:0] base;
  logic             invert;

  // codes 3..5 reuse the 0..2 path with an output inversion
  always_comb begin
    base   = '0;
    invert = 1'b0;
    bad    = 1'b0;
    unique case (func)
      LG_AND:   base = opb & opc;
      LG_OR:    base = opb | opc;
      LG_XOR:   base = opb ^ opc;
      LG_NAND:  begin base = opb & opc; invert = 1'b1; end
      LG_NOR:   begin base = opb | opc; invert = 1'b1; end
      LG_XNOR:  begin base = opb ^ opc; invert = 1'b1; end
      LG_CNIMP: base = ~opb & opc;
      LG_MNIMP: base = opb & ~opc;
      LG_MIMP:  base = ~opb | opc;
      LG_CIMP:  base = opb | ~opc;
      default:  bad  = 1'b1;
    endcase
    res = invert ? ~base : base;
  end

  always_comb begin
    if (!$isunknown({func, opb, opc})) begin
      if (func == LG_AND)
        AST_AND_INSIDE_OR: assert ((res & ~(opb | opc)) == '0); // R1
      if (func == LG_MIMP)
        AST_IMPL_COVERS: assert ((res | opb) == {WIDTH{1'b1}}); // R4
      if (func == LG_CNIMP)
        AST_CNIMP_DISJOINT: assert ((res & opb) == '0); // R3
    end
  end
endmodule

// File: rtl/slu_shift.sv
module slu_shift #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       func,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] opc,
  output logic [WIDTH-1:0] res,
  output logic             bad
);
  import slu_pkg::*;

  localparam int               SHW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [WIDTH-1:0] WID_V = WIDTH[WIDTH-1:0];

  logic             over;
  logic [SHW-1:0]   amt;
  logic [WIDTH-1:0] rot_w;
  logic [WIDTH-1:0] rot_back;
  logic [WIDTH-1:0] signfill;

  assign over     = (opc >= WID_V);
  assign amt      = opc[SHW-1:0];
  assign rot_w    = opc % WID_V;
  assign rot_back = WID_V - rot_w;
  assign signfill = {WIDTH{opb[WIDTH-1]}};

  always_comb begin
    res = '0;
    bad = 1'b0;
    unique case (func)
      SH_ALEFT, SH_ZLEFT: res = over ? '0 : (opb << amt);
      SH_ARIGHT: res = over ? signfill : WIDTH'($signed(opb) >>> amt);
      SH_ZRIGHT: res = over ? '0 : (opb >> amt);
      SH_OLEFT:  res = over ? {WIDTH{1'b1}} : ~((~opb) << amt);
      SH_ORIGHT: res = over ? {WIDTH{1'b1}} : ~((~opb) >> amt);
      SH_ROTL:   res = (opb << rot_w) | (opb >> rot_back);
      SH_ROTR:   res = (opb >> rot_w) | (opb << rot_back);
      default:   bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({func, opb, opc})) begin
      if (func == SH_ROTL || func == SH_ROTR)
        AST_ROT_KEEPS_ONES: assert ($countones(res) == $countones(opb)); // R10
      if (func == SH_ZLEFT || func == SH_ZRIGHT)
        AST_ZFILL_NO_GAIN: assert ($countones(res) <= $countones(opb)); // R7
      if (func == SH_OLEFT || func == SH_ORIGHT)
        AST_OFILL_NO_LOSS: assert ($countones(res) >= $countones(opb)); // R8
    end
  end
endmodule

// File: rtl/slu_top.sv
module slu_top #(
  parameter int WIDTH = 32
) (
  input  logic             grp_sel,
  input  logic [3:0]       func,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] opc,
  output logic [WIDTH-1:0] res,
  output logic             illegal
);
  import slu_pkg::*;

  logic [WIDTH-1:0] lg_res, sh_res;
  logic             lg_bad, sh_bad;

  slu_logic #(.WIDTH(WIDTH)) i_slu_logic (
    .func(func), .opb(opb), .opc(opc), .res(lg_res), .bad(lg_bad)
  );

  slu_shift #(.WIDTH(WIDTH)) i_slu_shift (
    .func(func), .opb(opb), .opc(opc), .res(sh_res), .bad(sh_bad)
  );

  always_comb begin
    if (grp_sel == GRP_SHIFT) begin
      illegal = sh_bad;
      res     = sh_bad ? '0 : sh_res;
    end else begin
      illegal = lg_bad;
      res     = lg_bad ? '0 : lg_res;
    end
  end

  always_comb begin
    if (!$isunknown({grp_sel, func})) begin
      if (illegal)
        AST_ILLEGAL_ZERO: assert (res == '0); // R5 R11
      if (func < 4'd8)
        AST_LOW_CODES_LEGAL: assert (!illegal); // R12
    end
  end
endmodule

// File: tb/test_slu_top.sv
module test_slu_top;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         grp_sel;
  logic [3:0]   func;
  logic [W-1:0] opb, opc, res;
  logic         illegal;
  int           total = 0;
  int           bad   = 0;

  slu_top #(.WIDTH(W)) i_slu_top (
    .grp_sel(grp_sel), .func(func), .opb(opb), .opc(opc),
    .res(res), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // drive on falling edge, sample 2 ns later
  task automatic apply_chk(input string req, input logic g, input logic [3:0] f,
                           input logic [W-1:0] b, input logic [W-1:0] c,
                           input logic [W-1:0] exp_r, input logic exp_i);
    @(negedge clk);
    grp_sel = g; func = f; opb = b; opc = c;
    #2;
    total++;
    if (res !== exp_r || illegal !== exp_i) begin
      bad++;
      $display("FAIL %s: g=%0d f=%0d b=%h c=%h got res=%h ill=%b exp res=%h ill=%b",
               req, g, f, b, c, res, illegal, exp_r, exp_i);
    end
  endtask

  // bit-by-bit reference for shifts; fill = value for vacated bits
  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] b, input logic [W-1:0] c,
                                             input logic left, input logic fill);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      longint src = left ? longint'(i) - longint'(c) : longint'(i) + longint'(c);
      r[i] = (src >= 0 && src < W) ? b[src] : fill;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_rot(input logic [W-1:0] b, input logic [W-1:0] c,
                                           input logic left);
    logic [W-1:0] r;
    int k = int'(c % W);
    for (int i = 0; i < W; i++)
      r[i] = left ? b[(i - k + W) % W] : b[(i + k) % W];
    return r;
  endfunction

  task automatic t_idle();
    apply_chk("R1 idle", 1'b0, 4'd0, '0, '0, '0, 1'b0);
  endtask

  task automatic t_logic_basic();
    logic [W-1:0] b = 32'hF0F0_3C3C, c = 32'hFF00_0FF0;
    apply_chk("R1 and", 0, 4'd0, b, c, 32'hF000_0C30, 0);
    apply_chk("R1 or",  0, 4'd1, b, c, 32'hFFF0_3FFC, 0);
    apply_chk("R1 xor", 0, 4'd2, b, c, 32'h0FF0_33CC, 0);
    apply_chk("R2 nand", 0, 4'd3, b, c, ~32'hF000_0C30, 0);
    apply_chk("R2 nor",  0, 4'd4, b, c, ~32'hFFF0_3FFC, 0);
    apply_chk("R2 xnor", 0, 4'd5, b, c, ~32'h0FF0_33CC, 0);
  endtask

  task automatic t_logic_impl();
    logic [W-1:0] b = 32'hAAAA_5555, c = 32'hCCCC_3333;
    apply_chk("R3 cnimp", 0, 4'd6, b, c, ~b & c, 0);
    apply_chk("R3 mnimp", 0, 4'd7, b, c, b & ~c, 0);
    apply_chk("R4 mimp",  0, 4'd8, b, c, ~b | c, 0);
    apply_chk("R4 cimp",  0, 4'd9, b, c, b | ~c, 0);
  endtask

  task automatic t_logic_reserved();
    for (int f = 10; f < 16; f++)
      apply_chk("R5 reserved", 0, 4'(f), 32'hDEAD_BEEF, 32'h1234_5678, '0, 1);
  endtask

  task automatic t_shifts();
    logic [W-1:0] neg = 32'h8123_4567, pos = 32'h4123_4567;
    int amts[4] = '{0, 1, 13, 31};
    foreach (amts[k]) begin
      logic [W-1:0] c = W'(amts[k]);
      apply_chk("R6 aleft",  1, 4'd0, neg, c, ref_shift(neg, c, 1, 0), 0);
      apply_chk("R6 aright neg", 1, 4'd1, neg, c, ref_shift(neg, c, 0, 1), 0);
      apply_chk("R6 aright pos", 1, 4'd1, pos, c, ref_shift(pos, c, 0, 0), 0);
      apply_chk("R7 zleft",  1, 4'd2, neg, c, ref_shift(neg, c, 1, 0), 0);
      apply_chk("R7 zright", 1, 4'd3, neg, c, ref_shift(neg, c, 0, 0), 0);
      apply_chk("R8 oleft",  1, 4'd4, pos, c, ref_shift(pos, c, 1, 1), 0);
      apply_chk("R8 oright", 1, 4'd5, pos, c, ref_shift(pos, c, 0, 1), 0);
    end
  endtask

  task automatic t_over();
    logic [W-1:0] neg = 32'h8000_0001, pos = 32'h7FFF_FFFE;
    logic [W-1:0] big[3] = '{32'd32, 32'd33, 32'h0000_0101};
    foreach (big[k]) begin
      apply_chk("R9 aleft",  1, 4'd0, neg, big[k], '0, 0);
      apply_chk("R9 aright neg", 1, 4'd1, neg, big[k], '1, 0);
      apply_chk("R9 aright pos", 1, 4'd1, pos, big[k], '0, 0);
      apply_chk("R9 zright", 1, 4'd3, neg, big[k], '0, 0);
      apply_chk("R9 oleft",  1, 4'd4, pos, big[k], '1, 0);
      apply_chk("R9 oright", 1, 4'd5, pos, big[k], '1, 0);
    end
  endtask

  task automatic t_rotates();
    logic [W-1:0] b = 32'h8000_00F1;
    int amts[5] = '{0, 4, 31, 32, 35};
    foreach (amts[k]) begin
      apply_chk("R10 rotl", 1, 4'd6, b, W'(amts[k]), ref_rot(b, W'(amts[k]), 1), 0);
      apply_chk("R10 rotr", 1, 4'd7, b, W'(amts[k]), ref_rot(b, W'(amts[k]), 0), 0);
    end
    apply_chk("R10 rotl fixed", 1, 4'd6, b, 32'd4, 32'h0000_0F18, 0);
  endtask

  task automatic t_shift_reserved();
    for (int f = 8; f < 16; f++)
      apply_chk("R11 reserved", 1, 4'(f), 32'hFFFF_FFFF, 32'd3, '0, 1);
  endtask

  task automatic t_legal_flags();
    for (int f = 0; f < 10; f++)
      apply_chk("R12 logic legal", 0, 4'(f), '0, '0, (f inside {3, 4, 5, 8, 9}) ? '1 : '0, 0);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; grp_sel = 1'b0; func = '0; opb = '0; opc = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_logic_basic();
    t_logic_impl();
    t_logic_reserved();
    t_shifts();
    t_over();
    t_rotates();
    t_shift_reserved();
    t_legal_flags();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule